// File: doc/BRIEF.md
# Order-Selectable Digit Password Comparator

This block decides whether a four-digit code typed by a player matches a four-digit code chosen by an operator. While the enter button is held, it raises exactly one of two outputs: an unlock strobe when the codes match, or a zap strobe when they do not. With enter released, both outputs stay low.

A mode input picks the matching rule. In positional mode every digit slot of the typed code must equal the same slot of the stored code. In any-order mode the typed digits only have to be a rearrangement of the stored digits, with repeated digits counted. The block is pure combinational logic. It has no clock and no storage, and the stored code is held outside the block.

Top module: `lock_cmp`

## Requirements
- R1: Each code bus carries four 4-bit slots. Slot k (k = 0..3) sits at bits [4k+3:4k], with bit 4k+3 as its MSB. Slot 3 is the most significant digit and slot 0 the least.
- R2: With `ordered` = 1 and `enter` = 1, `unlock` is 1 exactly when every user slot equals the password slot of the same index; otherwise `zap` is 1.
- R3: With `ordered` = 0 and `enter` = 1, `unlock` is 1 exactly when the four user digits are a permutation of the four password digits; otherwise `zap` is 1.
- R4: In any-order mode repeated digits must occur equally often on both sides: user 1,1,2,3 against password 1,2,3,3 gives `zap`.
- R5: Slot values 10 to 15 are compared as ordinary 4-bit values in both modes, with no special handling.
- R6: With `enter` = 0, `unlock` and `zap` are both 0 whatever the other inputs are.
- R7: `unlock` and `zap` are never 1 together, and with `enter` = 1 exactly one of them is 1.
- R8: The outputs depend only on the present inputs. They follow an input change without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| usr_code | input | 16 | Player's four digits, slot layout per R1 |
| pwd_code | input | 16 | Operator's four digits, slot layout per R1 |
| enter | input | 1 | Held high to request a verdict |
| ordered | input | 1 | 1 = positional match, 0 = any-order match |
| unlock | output | 1 | High while enter is held and the codes match |
| zap | output | 1 | High while enter is held and the codes differ |

## Verification
Positional equality and permutation equality hold at once whenever the two codes are identical. The two rules part ways only when the same digits appear in a different order or with different repeat counts. A full sweep over every pair of codes drawn from a three-value alphabet provokes all of these cases, each in both modes. The bench judges each vector against two independent references: a plain word compare, and a sort-then-compare. The same sweep shows that the two outputs never rise together, and that unlock in positional mode always implies unlock in any-order mode for the same inputs.

// File: rtl/lock_cmp_pkg.sv
package lock_cmp_pkg;

    // Matching rule selected by the mode pin.
    typedef enum logic {
        MODE_ANYORDER   = 1'b0,
        MODE_POSITIONAL = 1'b1
    } match_mode_e;

    // Outcome of both comparison engines.
    typedef struct packed {
        logic pos_eq;
        logic perm_eq;
    } match_flags_t;

    // Output decision, bit 0 drives unlock and bit 1 drives zap.
    typedef enum logic [1:0] {
        VERDICT_IDLE   = 2'b00,
        VERDICT_UNLOCK = 2'b01,
        VERDICT_ZAP    = 2'b10
    } verdict_e;

    // Width of a counter able to hold 0..n.
    function automatic int tally_width(input int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/lock_pos_match.sv
module lock_pos_match #(
    parameter int N_DIGITS = 4,
    parameter int DIGIT_W  = 4
) (
    input  logic [N_DIGITS*DIGIT_W-1:0] a_code,
    input  logic [N_DIGITS*DIGIT_W-1:0] b_code,
    output logic                        all_eq
);
    logic [N_DIGITS-1:0] slot_eq;

    for (genvar s = 0; s < N_DIGITS; s++) begin : g_slot
        assign slot_eq[s] = (a_code[s*DIGIT_W +: DIGIT_W] == b_code[s*DIGIT_W +: DIGIT_W]);
    end

    assign all_eq = &slot_eq;
endmodule

// File: rtl/lock_perm_match.sv
module lock_perm_match
    import lock_cmp_pkg::*;
#(
    parameter int N_DIGITS = 4,
    parameter int DIGIT_W  = 4
) (
    input  logic [N_DIGITS*DIGIT_W-1:0] a_code,
    input  logic [N_DIGITS*DIGIT_W-1:0] b_code,
    output logic                        perm_eq
);
    // Every digit present on either side is used as a probe key; the
    // two codes are multiset-equal when each key occurs equally often.
    localparam int KEYS = 2 * N_DIGITS;
    localparam int CW   = tally_width(N_DIGITS);

    logic [KEYS-1:0] key_ok;

    for (genvar k = 0; k < KEYS; k++) begin : g_key
        logic [DIGIT_W-1:0]  key;
        logic [N_DIGITS-1:0] hit_a;
        logic [N_DIGITS-1:0] hit_b;
        logic [CW-1:0]       cnt_a;
        logic [CW-1:0]       cnt_b;

        if (k < N_DIGITS) begin : g_from_a
            assign key = a_code[k*DIGIT_W +: DIGIT_W];
        end else begin : g_from_b
            assign key = b_code[(k-N_DIGITS)*DIGIT_W +: DIGIT_W];
        end

        for (genvar j = 0; j < N_DIGITS; j++) begin : g_cmp
            assign hit_a[j] = (a_code[j*DIGIT_W +: DIGIT_W] == key);
            assign hit_b[j] = (b_code[j*DIGIT_W +: DIGIT_W] == key);
        end

        always_comb begin
            cnt_a = '0;
            cnt_b = '0;
            for (int j = 0; j < N_DIGITS; j++) begin
                cnt_a = cnt_a + CW'(hit_a[j]);
                cnt_b = cnt_b + CW'(hit_b[j]);
            end
        end

        assign key_ok[k] = (cnt_a == cnt_b);
    end

    assign perm_eq = &key_ok;
endmodule

// File: rtl/lock_verdict.sv
module lock_verdict
    import lock_cmp_pkg::*;
(
    input  match_flags_t flags,
    input  match_mode_e  mode,
    input  logic         enter,
    output verdict_e     verdict
);
    logic hit;

    always_comb begin
        unique case (mode)
            MODE_POSITIONAL: hit = flags.pos_eq;
            MODE_ANYORDER:   hit = flags.perm_eq;
            default:         hit = 1'b0;
        endcase
    end

    always_comb begin
        if (!enter)   verdict = VERDICT_IDLE;
        else if (hit) verdict = VERDICT_UNLOCK;
        else          verdict = VERDICT_ZAP;
    end
endmodule

// File: rtl/lock_cmp.sv
module lock_cmp
    import lock_cmp_pkg::*;
#(
    parameter int N_DIGITS = 4,
    parameter int DIGIT_W  = 4
) (
    input  logic [N_DIGITS*DIGIT_W-1:0] usr_code,
    input  logic [N_DIGITS*DIGIT_W-1:0] pwd_code,
    input  logic                        enter,
    input  logic                        ordered,
    output logic                        unlock,
    output logic                        zap
);
    match_flags_t flags;
    match_mode_e  mode;
    verdict_e     verdict;

    assign mode = match_mode_e'(ordered);

    lock_pos_match #(.N_DIGITS(N_DIGITS), .DIGIT_W(DIGIT_W)) u_pos (
        .a_code (usr_code),
        .b_code (pwd_code),
        .all_eq (flags.pos_eq)
    );

    lock_perm_match #(.N_DIGITS(N_DIGITS), .DIGIT_W(DIGIT_W)) u_perm (
        .a_code  (usr_code),
        .b_code  (pwd_code),
        .perm_eq (flags.perm_eq)
    );

    lock_verdict u_verdict (
        .flags   (flags),
        .mode    (mode),
        .enter   (enter),
        .verdict (verdict)
    );

    assign unlock = verdict[0];
    assign zap    = verdict[1];
endmodule

// File: rtl/lock_cmp_chk.sv
module lock_cmp_chk #(
    parameter int N_DIGITS = 4,
    parameter int DIGIT_W  = 4
) (
    input logic [N_DIGITS*DIGIT_W-1:0] usr_code,
    input logic [N_DIGITS*DIGIT_W-1:0] pwd_code,
    input logic                        enter,
    input logic                        ordered,
    input logic                        unlock,
    input logic                        zap
);
    always_comb begin
        if (!$isunknown({usr_code, pwd_code, enter, ordered, unlock, zap})) begin
            // R6: released button keeps both outputs low
            a_r6_idle_quiet: assert (enter || (!unlock && !zap));
            // R7: outputs mutually exclusive, one active while pressed
            a_r7_one_active: assert (!(unlock && zap) && (!enter || (unlock || zap)));
            // R2: positional mode rejects any differing code
            a_r2_pos_mismatch_zaps: assert (!(enter && ordered && usr_code != pwd_code) || zap);
            // R2/R3: an identical code opens in either mode
            a_r3_identity_opens: assert (!(enter && usr_code == pwd_code) || unlock);
        end
    end
endmodule

bind lock_cmp lock_cmp_chk #(.N_DIGITS(N_DIGITS), .DIGIT_W(DIGIT_W)) u_chk (
    .usr_code (usr_code),
    .pwd_code (pwd_code),
    .enter    (enter),
    .ordered  (ordered),
    .unlock   (unlock),
    .zap      (zap)
);

// File: tb/sim_lock_cmp.sv
`timescale 1ns/1ps
module sim_lock_cmp;
    logic        clk = 1'b0;
    logic [15:0] usr_code;
    logic [15:0] pwd_code;
    logic        enter;
    logic        ordered;
    logic        unlock;
    logic        zap;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    lock_cmp u0 (
        .usr_code (usr_code),
        .pwd_code (pwd_code),
        .enter    (enter),
        .ordered  (ordered),
        .unlock   (unlock),
        .zap      (zap)
    );

    function automatic logic [15:0] sort4(input logic [15:0] c);
        logic [3:0] d [4];
        logic [3:0] t;
        for (int i = 0; i < 4; i++) d[i] = c[i*4 +: 4];
        for (int p = 0; p < 3; p++)
            for (int i = 0; i < 3 - p; i++)
                if (d[i] > d[i+1]) begin t = d[i]; d[i] = d[i+1]; d[i+1] = t; end
        return {d[3], d[2], d[1], d[0]};
    endfunction

    function automatic logic [1:0] model(input logic [15:0] u, input logic [15:0] p,
                                         input logic en, input logic ord);
        logic m;
        m = ord ? (u == p) : (sort4(u) == sort4(p));
        if (!en) return 2'b00;
        return m ? 2'b01 : 2'b10;
    endfunction

    task automatic check(input string req, input logic [1:0] exp);
        total++;
        if ({zap, unlock} !== exp) begin
            bad++;
            $display("FAIL %s usr=%h pwd=%h en=%0b ord=%0b got zap/unlock=%b exp=%b",
                     req, usr_code, pwd_code, enter, ordered, {zap, unlock}, exp);
        end
    endtask

    task automatic apply(input logic [15:0] u, input logic [15:0] p,
                         input logic en, input logic ord, input string req);
        @(posedge clk);
        usr_code = u; pwd_code = p; enter = en; ordered = ord;
        #1;
        check(req, model(u, p, en, ord));
    endtask

    initial begin
        usr_code = '0; pwd_code = '0; enter = 0; ordered = 0;
        #1;
        check("R6 reset idle", 2'b00);

        // R1: slot order matters only in positional mode
        apply(16'h4321, 16'h4321, 1, 1, "R1 same layout");
        apply(16'h4321, 16'h1234, 1, 1, "R1 reversed positional");
        apply(16'h4321, 16'h1234, 1, 0, "R1 reversed any-order");
        apply(16'h0001, 16'h1000, 1, 1, "R1 slot0 vs slot3");
        // R4: repeat counts
        apply(16'h1123, 16'h1233, 1, 0, "R4 1123 vs 1233");
        apply(16'h3121, 16'h1123, 1, 0, "R4 permuted repeats");
        apply(16'h7777, 16'h7770, 1, 0, "R4 quad vs triple");
        // R5: non-decimal codes
        apply(16'hFA0B, 16'hBF0A, 1, 0, "R5 high codes any-order");
        apply(16'hFA0B, 16'hBF0A, 1, 1, "R5 high codes positional");
        apply(16'hFFFF, 16'hFFFF, 1, 1, "R5 all fifteen");
        apply(16'hF000, 16'hE000, 1, 0, "R5 15 vs 14");
        // R6: enter low with matching code
        apply(16'h5555, 16'h5555, 0, 1, "R6 match released");
        apply(16'h1234, 16'h9876, 0, 0, "R6 mismatch released");

        // R8: change inputs between clock edges
        @(negedge clk);
        usr_code = 16'h2468; pwd_code = 16'h8642; enter = 1; ordered = 0;
        #0.5;
        check("R8 no-clock any-order", 2'b01);
        ordered = 1;
        #0.5;
        check("R8 no-clock positional", 2'b10);

        // R2/R3/R7: full sweep of digits 0..2, both modes
        for (int v = 0; v < 6561; v++) begin
            logic [15:0] u, p;
            int r;
            r = v;
            for (int s = 0; s < 4; s++) begin u[s*4 +: 4] = 4'(r % 3); r = r / 3; end
            for (int s = 0; s < 4; s++) begin p[s*4 +: 4] = 4'(r % 3); r = r / 3; end
            apply(u, p, 1, 1, "R2 sweep positional");
            apply(u, p, 1, 0, "R3 sweep any-order");
            if (v % 101 == 0) apply(u, p, 0, v[0], "R6 sweep released");
            total++;
            if (unlock && zap) begin
                bad++;
                $display("FAIL R7 both high usr=%h pwd=%h got=11 exp=not 11", u, p);
            end
        end

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog got=timeout exp=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule